// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor with Change-of-State Interrupt

This block watches a bipolar receive line, one bit period at a time, and decides whether the signal has been lost. A bit period exists only in a cycle where the bit-clock enable is high. In such a cycle a pulse on the positive strobe or the negative strobe counts as a mark. A long run of bit periods with no mark declares an internal loss. Recovery is slower and stricter: the line must show a minimum density of marks within a fixed window. The internal result is merged with a loss indication from the external line interface. The merged flag is the reported status.

Every change of the merged flag, whether it rises or falls, sets a sticky status bit. The interrupt request output is active low. It goes low while that bit is set and both a per-source enable and a block-level enable are on. Software reads the status register to clear the sticky bit. A small byte-wide register port holds the two enable registers and the status register.

Top module: `los_monitor`

## Requirements
- R1: With the internal flag clear, the flag is declared at the clock edge of the RUN_LEN-th (default 180) consecutive bit period without a mark. A mark restarts the run. Cycles with bit_en low are not bit periods, and any strobes in them are ignored.
- R2: A mark is a bit period in which rx_pos or rx_neg (or both) is high. Negative-only pulses count the same as positive-only pulses.
- R3: While the internal flag is set, bit periods are grouped into back-to-back, non-overlapping windows of WIN_LEN (default 180). The first window starts with the bit period after the declaration. The flag clears at the edge that ends a window holding at least MARK_MIN (default 60) marks, and never in the middle of a window.
- R4: los_status is the OR of the internal flag and ext_los. A high ext_los shows on los_status in the same cycle.
- R5: Each change of los_status, in either direction, sets the sticky status bit (bit 6 at address 0x13) one edge later. This happens whatever the enables are. A read of 0x13 returns the bit and clears it at that edge, unless a new change is being recorded at the same edge, in which case the bit stays set.
- R6: irq_n is low exactly while the sticky bit, the source enable (bit 6 at 0x12) and the block enable (bit 7 at 0x04) are all 1. Otherwise it is high.
- R7: Registers 0x04 and 0x12 are 8-bit read/write registers that reset to 0 and read back what was written. Register 0x13 reads as 0 except bit 6. Unmapped addresses read 0. reg_rdata is 0 when reg_rd is low.
- R8: After reset, los_status is 0 (with ext_los low), irq_n is 1 and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks a cycle as a receive bit period |
| rx_pos | input | 1 | Positive pulse strobe for the current bit |
| rx_neg | input | 1 | Negative pulse strobe for the current bit |
| ext_los | input | 1 | Loss indication from the line interface, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of 0x13 clears the sticky bit) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle reg_rd is high |
| los_status | output | 1 | Combined loss-of-signal status |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Some properties are checked on every cycle:
- The zero-run counter never passes its limit.
- The window mark count never exceeds the bits seen in that window.
- The internal flag only rises after a markless bit period, and only falls on a bit period.
- A high ext_los always shows on the status.
- The sticky bit only rises after a recorded change.
- irq_n is never low without both enables.

The exact declaration edge, the end-of-window recovery, the counting of negative-only marks, read-to-clear and its race with a new event, and the gating combinations can only be shown by the bench's directed scenarios.

// File: rtl/los_pkg.sv
// Shared constants for the loss-of-signal monitor: register map and field
// positions that software and the register block both rely on.
package los_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_BLK_EN = 8'h04;
    localparam logic [REG_AW-1:0] ADDR_SRC_EN = 8'h12;
    localparam logic [REG_AW-1:0] ADDR_STATUS = 8'h13;

    localparam int BIT_BLK_EN = 7;
    localparam int BIT_SRC_EN = 6;
    localparam int BIT_STATUS = 6;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_BLK,
        SEL_SRC,
        SEL_STAT
    } reg_sel_e;
endpackage

// File: rtl/los_zero_run.sv
// Counts consecutive bit periods without a mark and flags the period that
// completes a run of RUN_LEN. Assumes bit_en qualifies every bit period;
// the counter is held at zero while 'hold' (loss already declared) is high.
module los_zero_run #(
    parameter int RUN_LEN = 180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mark,
    input  logic hold,
    output logic run_hit
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] zcnt_q;
    logic          at_last;

    assign at_last = (zcnt_q == LAST);
    assign run_hit = bit_en & ~hold & ~mark & at_last;

    // Purpose: advance the zero run per markless bit, restart on mark or hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zcnt_q <= '0;
        end else if (hold) begin
            zcnt_q <= '0;
        end else if (bit_en) begin
            if (mark || at_last) zcnt_q <= '0;
            else                 zcnt_q <= zcnt_q + CW'(1);
        end
    end

    assert_run_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt_q <= LAST);
endmodule

// File: rtl/los_mark_window.sv
// While loss is declared, splits bit periods into back-to-back windows of
// WIN_LEN and signals recovery at the last period of a window holding at
// least MARK_MIN marks. Counters are held at zero while inactive.
module los_mark_window #(
    parameter int WIN_LEN  = 180,
    parameter int MARK_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic bit_en,
    input  logic mark,
    output logic win_ok
);
    localparam int BW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int MW = $clog2(WIN_LEN + 1);
    localparam logic [BW-1:0] LAST = BW'(WIN_LEN - 1);

    logic [BW-1:0] bcnt_q;
    logic [MW-1:0] mcnt_q;
    logic [MW:0]   total;
    logic          win_end;

    assign win_end = active & bit_en & (bcnt_q == LAST);
    assign total   = {1'b0, mcnt_q} + (MW+1)'(mark);
    assign win_ok  = win_end & (total >= (MW+1)'(MARK_MIN));

    // Purpose: count bits and marks inside the current window, restart at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            bcnt_q <= '0;
            mcnt_q <= '0;
        end else if (bit_en) begin
            if (win_end) begin
                bcnt_q <= '0;
                mcnt_q <= '0;
            end else begin
                bcnt_q <= bcnt_q + BW'(1);
                mcnt_q <= mcnt_q + MW'(mark);
            end
        end
    end

    assert_marks_le_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mcnt_q) <= int'(bcnt_q));
endmodule

// File: rtl/los_irq_regs.sv
// Register port and interrupt logic: two read/write enable registers, a
// sticky change-of-state bit cleared by reading its register, and the
// active-low request. Assumes single-cycle read and write strobes.
module los_irq_regs
    import los_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cos_evt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_n
);
    logic [REG_DW-1:0] blk_q;
    logic [REG_DW-1:0] src_q;
    logic              sticky_q;
    reg_sel_e          sel;
    logic              irq_on;

    // Purpose: decode the register address.
    always_comb begin
        unique case (reg_addr)
            ADDR_BLK_EN: sel = SEL_BLK;
            ADDR_SRC_EN: sel = SEL_SRC;
            ADDR_STATUS: sel = SEL_STAT;
            default:     sel = SEL_NONE;
        endcase
    end

    // Purpose: hold the enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
            src_q <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_BLK) blk_q <= reg_wdata;
            if (sel == SEL_SRC) src_q <= reg_wdata;
        end
    end

    // Purpose: sticky change-of-state bit, a new event wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           sticky_q <= 1'b0;
        else if (cos_evt)                     sticky_q <= 1'b1;
        else if (reg_rd && sel == SEL_STAT)   sticky_q <= 1'b0;
    end

    // Purpose: return read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (sel)
                SEL_BLK:  reg_rdata = blk_q;
                SEL_SRC:  reg_rdata = src_q;
                SEL_STAT: reg_rdata[BIT_STATUS] = sticky_q;
                default:  reg_rdata = '0;
            endcase
        end
    end

    assign irq_on = sticky_q & blk_q[BIT_BLK_EN] & src_q[BIT_SRC_EN];
    assign irq_n  = ~irq_on;

    assert_sticky_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_q) |-> $past(cos_evt));
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (blk_q[BIT_BLK_EN] && src_q[BIT_SRC_EN]));
endmodule

// File: rtl/los_monitor.sv
// Top of the loss-of-signal monitor. Holds the internal loss flag, merges
// it with the external indication, and turns each edge of the merged flag
// into a change-of-state event for the interrupt registers. Assumes all
// inputs are synchronous to clk.
module los_monitor
    import los_pkg::*;
#(
    parameter int RUN_LEN  = 180,
    parameter int WIN_LEN  = 180,
    parameter int MARK_MIN = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_pos,
    input  logic              rx_neg,
    input  logic              ext_los,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              los_status,
    output logic              irq_n
);
    logic mark;
    logic run_hit;
    logic win_ok;
    logic los_int_q;
    logic los_prev_q;
    logic cos_evt;

    assign mark       = rx_pos | rx_neg;
    assign los_status = los_int_q | ext_los;
    assign cos_evt    = los_status ^ los_prev_q;

    los_zero_run #(.RUN_LEN(RUN_LEN)) u_zero_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .mark    (mark),
        .hold    (los_int_q),
        .run_hit (run_hit)
    );

    los_mark_window #(.WIN_LEN(WIN_LEN), .MARK_MIN(MARK_MIN)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (los_int_q),
        .bit_en (bit_en),
        .mark   (mark),
        .win_ok (win_ok)
    );

    // Purpose: internal loss flag, set by a full zero run, cleared by a dense window.
    always_ff @(posedge clk) begin
        if (!rst_n)       los_int_q <= 1'b0;
        else if (run_hit) los_int_q <= 1'b1;
        else if (win_ok)  los_int_q <= 1'b0;
    end

    // Purpose: remember the merged flag to detect its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) los_prev_q <= 1'b0;
        else        los_prev_q <= los_status;
    end

    los_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cos_evt   (cos_evt),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    assert_declare_after_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_int_q) |-> ($past(bit_en) && !$past(rx_pos) && !$past(rx_neg)));
    assert_clear_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_int_q) |-> $past(bit_en));
    assert_ext_shows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_los |-> los_status);
endmodule

// File: tb/los_monitor_bench.sv
module los_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_pos = 1'b0;
    logic       rx_neg = 1'b0;
    logic       ext_los = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       los_status;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    los_monitor u_los_monitor (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pos(rx_pos),
        .rx_neg(rx_neg), .ext_los(ext_los), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .los_status(los_status), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic p, input logic n);
        bit_en = 1'b1; rx_pos = p; rx_neg = n;
        @(negedge clk);
        bit_en = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    endtask

    task automatic zeros(input int k);
        for (int i = 0; i < k; i++) send(1'b0, 1'b0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1ns d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] d;
        chk("R8 los_status after reset", 8'(los_status), 8'h0);
        chk("R8 irq_n after reset", 8'(irq_n), 8'h1);
        rd(8'h04, d); chk("R7 block enable reset", d, 8'h00);
        rd(8'h12, d); chk("R7 source enable reset", d, 8'h00);
        rd(8'h13, d); chk("R7 status reset", d, 8'h00);
        chk("R7 rdata idle", reg_rdata, 8'h00);
    endtask

    task automatic test_regs();
        logic [7:0] d;
        wr(8'h04, 8'hA5); rd(8'h04, d); chk("R7 block enable readback", d, 8'hA5);
        wr(8'h12, 8'h3C); rd(8'h12, d); chk("R7 source enable readback", d, 8'h3C);
        rd(8'h55, d); chk("R7 unmapped reads zero", d, 8'h00);
        wr(8'h04, 8'h00); wr(8'h12, 8'h00);
    endtask

    task automatic test_declare();
        logic [7:0] d;
        zeros(100);
        send(1'b1, 1'b0);
        zeros(179);
        chk("R1 no loss after 179 zeros past a mark", 8'(los_status), 8'h0);
        bit_en = 1'b0; rx_pos = 1'b1; rx_neg = 1'b1;
        tick();
        rx_pos = 1'b0; rx_neg = 1'b0;
        chk("R1 strobe without bit_en ignored", 8'(los_status), 8'h0);
        zeros(1);
        chk("R1 loss declared at 180th zero", 8'(los_status), 8'h1);
        tick();
        rd(8'h13, d); chk("R5 status set on declare", d, 8'h40);
        rd(8'h13, d); chk("R5 status cleared by read", d, 8'h00);
    endtask

    task automatic test_recover();
        logic [7:0] d;
        for (int i = 0; i < 59; i++) send(1'b1, 1'b0);
        zeros(121);
        chk("R3 window with 59 marks keeps loss", 8'(los_status), 8'h1);
        for (int i = 0; i < 30; i++) send(1'b0, 1'b1);
        for (int i = 0; i < 30; i++) send(1'b1, 1'b0);
        zeros(119);
        chk("R3 no clear before window end", 8'(los_status), 8'h1);
        zeros(1);
        chk("R2 R3 clear with 60 marks incl. negative", 8'(los_status), 8'h0);
        tick();
        rd(8'h13, d); chk("R5 status set on clear", d, 8'h40);
    endtask

    task automatic test_ext();
        logic [7:0] d;
        wr(8'h04, 8'h80); wr(8'h12, 8'h40);
        chk("R6 no irq without event", 8'(irq_n), 8'h1);
        ext_los = 1'b1;
        #1ns chk("R4 ext shows same cycle", 8'(los_status), 8'h1);
        tick();
        chk("R6 irq low on rise", 8'(irq_n), 8'h0);
        rd(8'h13, d); chk("R5 status after ext rise", d, 8'h40);
        chk("R6 irq released after read", 8'(irq_n), 8'h1);
        ext_los = 1'b0;
        #1ns chk("R4 ext release", 8'(los_status), 8'h0);
        tick();
        chk("R6 irq low on fall", 8'(irq_n), 8'h0);
        rd(8'h13, d);
        chk("R6 irq released after second read", 8'(irq_n), 8'h1);
    endtask

    task automatic test_gate();
        logic [7:0] d;
        wr(8'h04, 8'h00);
        ext_los = 1'b1; tick(); tick();
        chk("R6 block enable off blocks irq", 8'(irq_n), 8'h1);
        rd(8'h13, d); chk("R5 status set with block off", d, 8'h40);
        wr(8'h04, 8'h80); wr(8'h12, 8'h00);
        ext_los = 1'b0; tick(); tick();
        chk("R6 source enable off blocks irq", 8'(irq_n), 8'h1);
        wr(8'h12, 8'h40);
        chk("R6 irq on once source enabled", 8'(irq_n), 8'h0);
        rd(8'h13, d);
    endtask

    task automatic test_race();
        logic [7:0] d;
        ext_los = 1'b1; reg_rd = 1'b1; reg_addr = 8'h13;
        #1ns d = reg_rdata;
        chk("R5 racing read sees old value", d, 8'h00);
        tick();
        reg_rd = 1'b0;
        rd(8'h13, d); chk("R5 event wins over clearing read", d, 8'h40);
        ext_los = 1'b0; tick(); rd(8'h13, d);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_regs();
        test_declare();
        test_recover();
        test_ext();
        test_gate();
        test_race();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..all: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule